// File: doc/BRIEF.md
# Power-On Strap Sampler with Shared Mode/Suspend Pin

This block reads a set of configuration strap inputs once after an active-low reset and turns them into steady configuration outputs. The outputs are the downstream port count, a mask of ports that are not removable, the polarity of the external power-switch enable and the reference clock selection. The captured values stay frozen until the next reset. A reserved clock-select code is flagged and handled as the 12 MHz setting.

One board pin does two jobs. Right after reset it is an input, and its level is captured at the sampling point to choose between ganged and per-port power switching. After a longer fixed delay the block turns the pin into an output, and from then on it reports global suspend. The level it drives for suspend depends on the mode that was captured. Both delays are counted in clock cycles and derived from the clock frequency and the delays in microseconds, all set by parameters. Pad electrical behaviour is handled outside this block: it only supplies the pin's output enable and output value, and it receives the pin's input level.

Top module: `pwron_strap_cfg`

## Requirements
- R1: The port count comes from the 2-bit strap `pnum_strap`, decoded as 2'b11 → 1, 2'b10 → 2, 2'b01 → 3 and 2'b00 → 4. The result appears on the 3-bit `port_count`.
- R2: `nonremov_mask[i]` is 1 exactly when `fixed_strap[i]` was high at the sampling point. Bit i stands for downstream port i+1.
- R3: `pwr_en_active_high` equals the level `pol_strap` had at the sampling point. A 1 means the power-switch enable is active-high and a 0 means it is active-low.
- R4: The bits of `clk_strap` are, from [1] to [0], the 48 MHz select and then the 27 MHz select. 2'b01 gives `refclk_sel` = 2 (48 MHz oscillator), 2'b10 gives 1 (27 MHz oscillator) and 2'b11 gives 0 (12 MHz crystal or oscillator). The reserved code 2'b00 gives `refclk_sel` = 0 with `refclk_code_err` = 1. Every other code gives `refclk_code_err` = 0.
- R5: All straps are captured at the clock edge SAMPLE_CNT = (CLK_FREQ_HZ/1000)·SAMPLE_US/1000 after reset is released, and `cfg_valid` rises at that same edge. Before it, `port_count`, `nonremov_mask`, `pwr_en_active_high`, `refclk_sel`, `refclk_code_err`, `gang_mode` and `cfg_valid` all read 0.
- R6: `gang_mode` equals the level `mode_pin_in` had at the sampling point. A 1 means ganged power switching and a 0 means per-port switching.
- R7: `mode_pin_oe` stays 0 until edge HANDOVER_CNT = (CLK_FREQ_HZ/1000)·HANDOVER_US/1000 after reset release. It goes to 1 at that edge and stays 1 until the next reset.
- R8: `mode_pin_out` is registered from `global_suspend`, one cycle later. In gang mode it is 1 in suspend and 0 otherwise. In per-port mode it is 0 in suspend and 1 otherwise.
- R9: Strap changes after the sampling point have no effect on any configuration output.
- R10: Asserting reset at any time clears all outputs and returns the pin to input. The next release samples the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; its release starts the timing |
| pnum_strap | input | 2 | Port-count strap pair |
| fixed_strap | input | 4 | Non-removable strap, one per port |
| pol_strap | input | 1 | Power-switch enable polarity strap |
| clk_strap | input | 2 | Reference clock select strap pair |
| mode_pin_in | input | 1 | Input level of the shared mode/suspend pin |
| global_suspend | input | 1 | High while the hub is globally suspended |
| mode_pin_oe | output | 1 | Output enable for the shared pin |
| mode_pin_out | output | 1 | Value driven onto the shared pin |
| cfg_valid | output | 1 | High once straps have been captured |
| port_count | output | 3 | Decoded number of downstream ports |
| nonremov_mask | output | 4 | Non-removable port mask |
| pwr_en_active_high | output | 1 | Power-switch enable polarity |
| refclk_sel | output | 2 | Reference clock selection |
| refclk_code_err | output | 1 | Reserved clock code was strapped |
| gang_mode | output | 1 | Captured power-switching mode |

## Verification
The assertions watch, on every cycle, the properties that do not depend on particular strap values:
- the captured configuration never changes while `cfg_valid` is high;
- the shared pin is never driven before the configuration is valid, and once driven it stays driven;
- the reserved-code flag only ever comes with the 12 MHz selection;
- the pin's output level follows the previous cycle's suspend input with the polarity the captured mode calls for.

Only the bench scenarios can show the rest:
- the exact decode of each strap pattern;
- the exact edges at which sampling and handover occur;
- that strap changes after sampling are ignored;
- that a reset in mid-operation takes the pin back to input and samples the straps again.

// File: rtl/pwron_strap_pkg.sv
package pwron_strap_pkg;

  typedef enum logic [1:0] {
    REF_12M = 2'd0,
    REF_27M = 2'd1,
    REF_48M = 2'd2
  } refclk_e;

  // Strap pair codes for the clock select
  localparam logic [1:0] CLKCODE_RSVD = 2'b00;
  localparam logic [1:0] CLKCODE_48M  = 2'b01;
  localparam logic [1:0] CLKCODE_27M  = 2'b10;
  localparam logic [1:0] CLKCODE_12M  = 2'b11;

  function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1000) * us / 1000;
  endfunction

endpackage

// File: rtl/pwron_strap_timer.sv
module pwron_strap_timer #(
  parameter int unsigned SAMPLE_CNT   = 240,
  parameter int unsigned HANDOVER_CNT = 600000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_now,
  output logic cfg_valid,
  output logic pin_handover
);

  localparam int unsigned CNT_W = $clog2(HANDOVER_CNT + 1);
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_CNT - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LIM = CNT_W'(SAMPLE_CNT);
  localparam logic [CNT_W-1:0] HANDOVER_LIM = CNT_W'(HANDOVER_CNT);

  logic [CNT_W-1:0] elapsed_q;

  // Saturating count of edges since reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (elapsed_q != HANDOVER_LIM) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  always_comb begin
    sample_now   = (elapsed_q == SAMPLE_AT);
    cfg_valid    = (elapsed_q >= SAMPLE_LIM);
    pin_handover = (elapsed_q == HANDOVER_LIM);
  end

endmodule

// File: rtl/pwron_strap_capture.sv
module pwron_strap_capture
  import pwron_strap_pkg::*;
#(
  parameter int unsigned PNUM_W    = 2,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PC_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_now,
  input  logic [PNUM_W-1:0]    pnum_strap,
  input  logic [NUM_PORTS-1:0] fixed_strap,
  input  logic                 pol_strap,
  input  logic [1:0]           clk_strap,
  output logic [PC_W-1:0]      port_count,
  output logic [NUM_PORTS-1:0] nonremov_mask,
  output logic                 pwr_en_active_high,
  output refclk_e              refclk_sel,
  output logic                 refclk_code_err
);

  logic [PC_W-1:0] count_d;
  refclk_e         refclk_d;
  logic            rsvd_d;

  // All-ones strap code means one port; each step down adds a port
  always_comb begin
    count_d = PC_W'(NUM_PORTS) - PC_W'(pnum_strap);
  end

  always_comb begin
    rsvd_d = 1'b0;
    unique case (clk_strap)
      CLKCODE_48M: refclk_d = REF_48M;
      CLKCODE_27M: refclk_d = REF_27M;
      CLKCODE_12M: refclk_d = REF_12M;
      default: begin
        refclk_d = REF_12M;
        rsvd_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_count         <= '0;
      pwr_en_active_high <= 1'b0;
      refclk_sel         <= REF_12M;
      refclk_code_err    <= 1'b0;
    end else if (sample_now) begin
      port_count         <= count_d;
      pwr_en_active_high <= pol_strap;
      refclk_sel         <= refclk_d;
      refclk_code_err    <= rsvd_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic fixed_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fixed_q <= 1'b0;
      end else if (sample_now) begin
        fixed_q <= fixed_strap[p];
      end
    end
    assign nonremov_mask[p] = fixed_q;
  end

endmodule

// File: rtl/pwron_mode_pin.sv
module pwron_mode_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_now,
  input  logic pin_handover,
  input  logic mode_pin_in,
  input  logic global_suspend,
  output logic gang_mode,
  output logic mode_pin_oe,
  output logic mode_pin_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gang_mode <= 1'b0;
    end else if (sample_now) begin
      gang_mode <= mode_pin_in;
    end
  end

  // Gang mode signals suspend high; per-port mode signals it low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pin_out <= 1'b0;
    end else begin
      mode_pin_out <= gang_mode ? global_suspend : ~global_suspend;
    end
  end

  assign mode_pin_oe = pin_handover;

endmodule

// File: rtl/pwron_strap_cfg.sv
module pwron_strap_cfg
  import pwron_strap_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 12_000_000,
  parameter int unsigned SAMPLE_US    = 20,
  parameter int unsigned HANDOVER_US  = 50_000,
  parameter int unsigned PNUM_W       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pnum_strap,
  input  logic [3:0] fixed_strap,
  input  logic       pol_strap,
  input  logic [1:0] clk_strap,
  input  logic       mode_pin_in,
  input  logic       global_suspend,
  output logic       mode_pin_oe,
  output logic       mode_pin_out,
  output logic       cfg_valid,
  output logic [2:0] port_count,
  output logic [3:0] nonremov_mask,
  output logic       pwr_en_active_high,
  output logic [1:0] refclk_sel,
  output logic       refclk_code_err,
  output logic       gang_mode
);

  localparam int unsigned NUM_PORTS    = 2 ** PNUM_W;
  localparam int unsigned PC_W         = $clog2(NUM_PORTS + 1);
  localparam int unsigned SAMPLE_CNT   = us_to_cycles(CLK_FREQ_HZ, SAMPLE_US);
  localparam int unsigned HANDOVER_CNT = us_to_cycles(CLK_FREQ_HZ, HANDOVER_US);

  logic    sample_now;
  logic    pin_handover;
  refclk_e refclk_q;

  pwron_strap_timer #(
    .SAMPLE_CNT   (SAMPLE_CNT),
    .HANDOVER_CNT (HANDOVER_CNT)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_now   (sample_now),
    .cfg_valid    (cfg_valid),
    .pin_handover (pin_handover)
  );

  pwron_strap_capture #(
    .PNUM_W    (PNUM_W),
    .NUM_PORTS (NUM_PORTS),
    .PC_W      (PC_W)
  ) u_capture (
    .clk                (clk),
    .rst_n              (rst_n),
    .sample_now         (sample_now),
    .pnum_strap         (pnum_strap),
    .fixed_strap        (fixed_strap),
    .pol_strap          (pol_strap),
    .clk_strap          (clk_strap),
    .port_count         (port_count),
    .nonremov_mask      (nonremov_mask),
    .pwr_en_active_high (pwr_en_active_high),
    .refclk_sel         (refclk_q),
    .refclk_code_err    (refclk_code_err)
  );

  pwron_mode_pin u_mode_pin (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_now     (sample_now),
    .pin_handover   (pin_handover),
    .mode_pin_in    (mode_pin_in),
    .global_suspend (global_suspend),
    .gang_mode      (gang_mode),
    .mode_pin_oe    (mode_pin_oe),
    .mode_pin_out   (mode_pin_out)
  );

  assign refclk_sel = refclk_q;

endmodule

// File: rtl/pwron_strap_cfg_chk.sv
module pwron_strap_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       global_suspend,
  input logic       mode_pin_oe,
  input logic       mode_pin_out,
  input logic       cfg_valid,
  input logic [2:0] port_count,
  input logic [3:0] nonremov_mask,
  input logic       pwr_en_active_high,
  input logic [1:0] refclk_sel,
  input logic       refclk_code_err,
  input logic       gang_mode
);

  // R4: reserved code always falls back to the 12 MHz selection
  a_r4_rsvd_is_12m: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_code_err |-> refclk_sel == 2'd0);

  // R5: nothing reported before sampling
  a_r5_idle_before_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (port_count == 3'd0 && nonremov_mask == 4'd0 && !refclk_code_err && !gang_mode));

  // R7: pin driven only after configuration, and it stays driven
  a_r7_oe_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pin_oe |-> cfg_valid);

  a_r7_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_pin_oe) |-> mode_pin_oe);

  // R8: suspend polarity follows captured mode, one cycle later
  a_r8_suspend_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pin_oe && $past(mode_pin_oe)) |->
      mode_pin_out == (gang_mode ? $past(global_suspend) : !$past(global_suspend)));

  // R9: captured configuration frozen once valid
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid)) |->
      ($stable(port_count) && $stable(nonremov_mask) && $stable(pwr_en_active_high) &&
       $stable(refclk_sel) && $stable(refclk_code_err) && $stable(gang_mode)));

  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid) |-> cfg_valid);

endmodule

bind pwron_strap_cfg pwron_strap_cfg_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .global_suspend     (global_suspend),
  .mode_pin_oe        (mode_pin_oe),
  .mode_pin_out       (mode_pin_out),
  .cfg_valid          (cfg_valid),
  .port_count         (port_count),
  .nonremov_mask      (nonremov_mask),
  .pwr_en_active_high (pwr_en_active_high),
  .refclk_sel         (refclk_sel),
  .refclk_code_err    (refclk_code_err),
  .gang_mode          (gang_mode)
);

// File: tb/pwron_strap_cfg_test.sv
`timescale 1ns/1ps
module pwron_strap_cfg_test;

  localparam int unsigned CLK_HZ   = 1_000_000;
  localparam int unsigned S_US     = 20;
  localparam int unsigned H_US     = 100;
  localparam int SAMPLE_N   = 20;   // 1000 * 20 / 1000
  localparam int HANDOVER_N = 100;  // 1000 * 100 / 1000
  localparam int NVEC = 5;

  // stim: pnum[21:20] fixed[19:16] pol[15] clk[14:13] mode[12]
  // exp : count[11:9] mask[8:5] pol[4] sel[3:2] err[1] gang[0]
  localparam logic [21:0] VEC [NVEC] = '{
    {2'b11, 4'b0000, 1'b0, 2'b11, 1'b0,  3'd1, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0},
    {2'b10, 4'b0101, 1'b1, 2'b01, 1'b1,  3'd2, 4'b0101, 1'b1, 2'd2, 1'b0, 1'b1},
    {2'b01, 4'b1010, 1'b0, 2'b10, 1'b1,  3'd3, 4'b1010, 1'b0, 2'd1, 1'b0, 1'b1},
    {2'b00, 4'b1111, 1'b1, 2'b00, 1'b0,  3'd4, 4'b1111, 1'b1, 2'd0, 1'b1, 1'b0},
    {2'b00, 4'b1000, 1'b0, 2'b01, 1'b0,  3'd4, 4'b1000, 1'b0, 2'd2, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pnum_strap = '0;
  logic [3:0] fixed_strap = '0;
  logic pol_strap = 1'b0;
  logic [1:0] clk_strap = '0;
  logic mode_pin_in = 1'b0;
  logic global_suspend = 1'b0;
  logic mode_pin_oe, mode_pin_out, cfg_valid, pwr_en_active_high, refclk_code_err, gang_mode;
  logic [2:0] port_count;
  logic [3:0] nonremov_mask;
  logic [1:0] refclk_sel;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwron_strap_cfg #(
    .CLK_FREQ_HZ (CLK_HZ),
    .SAMPLE_US   (S_US),
    .HANDOVER_US (H_US)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .pnum_strap (pnum_strap), .fixed_strap (fixed_strap), .pol_strap (pol_strap),
    .clk_strap (clk_strap), .mode_pin_in (mode_pin_in), .global_suspend (global_suspend),
    .mode_pin_oe (mode_pin_oe), .mode_pin_out (mode_pin_out), .cfg_valid (cfg_valid),
    .port_count (port_count), .nonremov_mask (nonremov_mask),
    .pwr_en_active_high (pwr_en_active_high), .refclk_sel (refclk_sel),
    .refclk_code_err (refclk_code_err), .gang_mode (gang_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apply(input logic [9:0] s);
    pnum_strap  = s[9:8];
    fixed_strap = s[7:4];
    pol_strap   = s[3];
    clk_strap   = s[2:1];
    mode_pin_in = s[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    edges(2);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_cfg(input string tag, input logic [11:0] e);
    check({tag, " R1 port_count"}, 32'(port_count), 32'(e[11:9]));
    check({tag, " R2 nonremov_mask"}, 32'(nonremov_mask), 32'(e[8:5]));
    check({tag, " R3 pwr polarity"}, 32'(pwr_en_active_high), 32'(e[4]));
    check({tag, " R4 refclk_sel"}, 32'(refclk_sel), 32'(e[3:2]));
    check({tag, " R4 refclk_code_err"}, 32'(refclk_code_err), 32'(e[1]));
    check({tag, " R6 gang_mode"}, 32'(gang_mode), 32'(e[0]));
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Reset state (R5, R7)
    edges(2);
    check("R5 reset cfg_valid", 32'(cfg_valid), 0);
    check("R5 reset port_count", 32'(port_count), 0);
    check("R7 reset oe", 32'(mode_pin_oe), 0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][21:12]);
      global_suspend = 1'b0;
      do_reset();
      // negedge after release: edge 1 is next posedge
      edges(SAMPLE_N - 1);
      check("R5 not yet valid", 32'(cfg_valid), 0);
      check("R5 not yet sampled", 32'(port_count), 0);
      edges(1);
      check("R5 valid at sample edge", 32'(cfg_valid), 1);
      check_cfg($sformatf("vec%0d", i), VEC[i][11:0]);
      // R9: flip every strap after sampling
      apply(~VEC[i][21:12]);
      edges(3);
      check_cfg($sformatf("vec%0d R9 frozen", i), VEC[i][11:0]);
      edges(HANDOVER_N - SAMPLE_N - 4);
      check("R7 oe still low", 32'(mode_pin_oe), 0);
      edges(1);
      check("R7 oe at handover", 32'(mode_pin_oe), 1);
      // R8: normal, then suspend
      global_suspend = 1'b0;
      edges(1);
      check("R8 normal level", 32'(mode_pin_out), VEC[i][0] ? 0 : 1);
      global_suspend = 1'b1;
      edges(1);
      check("R8 suspend level", 32'(mode_pin_out), VEC[i][0] ? 1 : 0);
      edges(5);
      check("R7 oe sticky", 32'(mode_pin_oe), 1);
    end

    // R10: reset mid-operation returns pin to input and resamples
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 oe cleared", 32'(mode_pin_oe), 0);
    check("R10 valid cleared", 32'(cfg_valid), 0);
    check("R10 mask cleared", 32'(nonremov_mask), 0);
    apply(VEC[1][21:12]);
    edges(2);
    @(negedge clk);
    rst_n = 1'b1;
    edges(SAMPLE_N);
    check_cfg("R10 resample", VEC[1][11:0]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule